// File: doc/BRIEF.md
# Double-Buffered Compare PWM Channel

This block is a single timer channel that turns a shared 24-bit time-base bus into a pulse-width-modulated output. It holds two active compare values. When the time base equals the first one, the output moves to the active level. When it equals the second one, the output moves to the inactive level. A polarity input decides which logic level counts as active. Comparisons take place only on cycles where the counter clock enable is high.

Software writes compare values into buffer registers. A select input decides when a buffered value becomes active. In immediate mode the value takes effect on the next cycle. In period mode it waits for the next first-compare match, which marks the start of a period.

Two strobes let software drive the output straight to the active or inactive level. A sticky flag records second-compare matches and is cleared by writing one. When the channel is switched into PWM operation, the output starts at the inactive level. Fixed rules give a 100% duty waveform when both compare values are equal and a 0% duty waveform when the first compare value is zero.

Top module: `ocpwm_channel`

## Requirements
- R1: While rst_n is low, at the clock edge pwm_out and match_flag both become 0, and the active and buffered compare values are all cleared to 0.
- R2: In the first cycle in which run_en is high after having been low, the output is loaded at the clock edge with the inverse of act_pol, whatever the other inputs are.
- R3: A match of the time base with cmp_a alone, where cmp_a is nonzero, sets pwm_out to act_pol at the next edge. A match with cmp_b alone sets pwm_out to the inverse of act_pol.
- R4: When both compares match in the same cycle and cmp_a is nonzero, pwm_out goes to act_pol. With equal compare values this repeats every period and gives 100% duty.
- R5: When cmp_a is zero, a cmp_a match sets pwm_out to the inverse of act_pol, even if cmp_b also matches. This makes a zero cmp_a, and a zero pair, produce 0% duty.
- R6: Matches count only in cycles where both cnt_tick and run_en are high. When run_en is low, pwm_out holds its value.
- R7: With upd_sel = 0, a write through wr_a or wr_b changes the active compare value at the edge that captures the write.
- R8: With upd_sel = 1, writes land only in the buffers. Both buffers are copied to the active compare values at the edge of a cmp_a match, and the matches judged in that cycle use the old values.
- R9: frc_act drives pwm_out to act_pol and frc_inact drives it to the inverse of act_pol. If both strobes are high, frc_inact wins. Either strobe overrides a compare match in the same cycle. Neither strobe changes match_flag.
- R10: A cmp_b match sets match_flag. A flag_w1c pulse clears it. When a set and a clear fall in the same cycle, the flag ends up set.
- R11: Compare matches keep toggling pwm_out while match_flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Counter clock enable; compares are judged only when high |
| tbase | input | 24 | Shared time-base bus |
| run_en | input | 1 | PWM operation enable; a rising level triggers the entry state |
| act_pol | input | 1 | Active output level |
| upd_sel | input | 1 | 0: write goes active at once, 1: at the next cmp_a match |
| wr_a | input | 1 | Write strobe for compare A |
| wr_b | input | 1 | Write strobe for compare B |
| wr_data | input | 24 | Compare value to write |
| frc_act | input | 1 | Force the output to the active level |
| frc_inact | input | 1 | Force the output to the inactive level |
| flag_w1c | input | 1 | Clear strobe for the match flag |
| pwm_out | output | 1 | PWM output |
| match_flag | output | 1 | Sticky flag set by a cmp_b match |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is setting the flag on a cmp_b match and clearing it through flag_w1c. The second pair is a force strobe and a compare match. The bench provokes each pair by pulsing the strobe in the very cycle where the time base equals cmp_b with cnt_tick high. It then judges the outcome one edge later: the flag must stay set, and the output must follow the force rather than the match. The same-cycle A/B match rules for 100% and 0% duty are judged the same way, with equal or zero compare values.

// File: rtl/ocpwm_pkg.sv
// Shared types for the compare PWM channel.
// Assumes: nothing beyond IEEE 1800-2017.
package ocpwm_pkg;
    // Output action chosen for one clock edge.
    typedef enum logic [1:0] {
        DRV_HOLD  = 2'd0,
        DRV_ACT   = 2'd1,
        DRV_INACT = 2'd2
    } drive_e;
endpackage

// File: rtl/ocpwm_cmp.sv
// Equality comparator between the time base and one active compare value.
// Assumes: en already combines the tick enable and the run enable.
module ocpwm_cmp #(
    parameter int W = 24
) (
    input  logic         en,
    input  logic [W-1:0] tbase,
    input  logic [W-1:0] ref_val,
    output logic         hit
);
    // Match only on enabled cycles.
    always_comb begin
        hit = en && (tbase == ref_val);
    end
endmodule

// File: rtl/ocpwm_regs.sv
// Buffered and active compare values for channel A and B.
// Assumes: xfer pulses on a cmp_a match and is used only in period mode.
module ocpwm_regs #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_sel,
    input  logic         wr_a,
    input  logic         wr_b,
    input  logic [W-1:0] wr_data,
    input  logic         xfer,
    output logic [W-1:0] a_act,
    output logic [W-1:0] b_act
);
    logic [W-1:0] a_buf;
    logic [W-1:0] b_buf;

    // Buffer stage: every write lands here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_buf <= '0;
            b_buf <= '0;
        end else begin
            if (wr_a) a_buf <= wr_data;
            if (wr_b) b_buf <= wr_data;
        end
    end

    // Active stage: immediate copy of writes, or buffer copy at a period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_act <= '0;
            b_act <= '0;
        end else if (!upd_sel) begin
            if (wr_a) a_act <= wr_data;
            if (wr_b) b_act <= wr_data;
        end else if (xfer) begin
            a_act <= a_buf;
            b_act <= b_buf;
        end
    end
endmodule

// File: rtl/ocpwm_drive.sv
// Output flip-flop and sticky match flag.
// Assumes: hit_a/hit_b are already gated by tick and run enable.
module ocpwm_drive
    import ocpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic act_pol,
    input  logic hit_a,
    input  logic hit_b,
    input  logic a_zero,
    input  logic frc_act,
    input  logic frc_inact,
    input  logic flag_w1c,
    output logic pwm_out,
    output logic match_flag,
    output logic run_q
);
    drive_e drv;

    // Choose the action: entry, then force, then compare matches.
    always_comb begin
        drv = DRV_HOLD;
        if (!run_en)        drv = DRV_HOLD;
        else if (!run_q)    drv = DRV_INACT;
        else if (frc_inact) drv = DRV_INACT;
        else if (frc_act)   drv = DRV_ACT;
        else if (hit_a)     drv = a_zero ? DRV_INACT : DRV_ACT;
        else if (hit_b)     drv = DRV_INACT;
    end

    // Output flip-flop and previous run enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_out <= 1'b0;
            run_q   <= 1'b0;
        end else begin
            run_q <= run_en;
            case (drv)
                DRV_ACT:   pwm_out <= act_pol;
                DRV_INACT: pwm_out <= ~act_pol;
                default:   pwm_out <= pwm_out;
            endcase
        end
    end

    // Sticky flag: a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        match_flag <= 1'b0;
        else if (hit_b)    match_flag <= 1'b1;
        else if (flag_w1c) match_flag <= 1'b0;
    end
endmodule

// File: rtl/ocpwm_channel.sv
// Top: double-buffered compare PWM channel on a shared time base.
// Assumes: the time base advances outside this block; cnt_tick qualifies it.
module ocpwm_channel #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_tick,
    input  logic [W-1:0] tbase,
    input  logic         run_en,
    input  logic         act_pol,
    input  logic         upd_sel,
    input  logic         wr_a,
    input  logic         wr_b,
    input  logic [W-1:0] wr_data,
    input  logic         frc_act,
    input  logic         frc_inact,
    input  logic         flag_w1c,
    output logic         pwm_out,
    output logic         match_flag
);
    logic [W-1:0] a_act;
    logic [W-1:0] b_act;
    logic         cmp_en;
    logic         hit_a;
    logic         hit_b;
    logic         run_q;

    // Compare enable: tick while running.
    always_comb cmp_en = cnt_tick && run_en;

    ocpwm_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .upd_sel(upd_sel),
        .wr_a(wr_a), .wr_b(wr_b), .wr_data(wr_data),
        .xfer(hit_a), .a_act(a_act), .b_act(b_act)
    );

    ocpwm_cmp #(.W(W)) u_cmp_a (
        .en(cmp_en), .tbase(tbase), .ref_val(a_act), .hit(hit_a)
    );

    ocpwm_cmp #(.W(W)) u_cmp_b (
        .en(cmp_en), .tbase(tbase), .ref_val(b_act), .hit(hit_b)
    );

    ocpwm_drive u_drive (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .act_pol(act_pol),
        .hit_a(hit_a), .hit_b(hit_b), .a_zero(a_act == '0),
        .frc_act(frc_act), .frc_inact(frc_inact), .flag_w1c(flag_w1c),
        .pwm_out(pwm_out), .match_flag(match_flag), .run_q(run_q)
    );
endmodule

// File: rtl/ocpwm_checker.sv
// Property checker for ocpwm_channel, attached by bind.
// Assumes: a_act/b_act/run_q are the top's internal register outputs.
module ocpwm_checker #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_tick,
    input logic [W-1:0] tbase,
    input logic         run_en,
    input logic         act_pol,
    input logic         upd_sel,
    input logic         frc_act,
    input logic         frc_inact,
    input logic         flag_w1c,
    input logic [W-1:0] a_act,
    input logic [W-1:0] b_act,
    input logic         run_q,
    input logic         pwm_out,
    input logic         match_flag
);
    logic on_a;
    logic on_b;
    logic steady;
    always_comb begin
        on_a   = cnt_tick && run_en && (tbase == a_act);
        on_b   = cnt_tick && run_en && (tbase == b_act);
        steady = run_en && run_q && !frc_act && !frc_inact;
    end

    a_r2_entry_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !run_q) |=> (pwm_out == !$past(act_pol)));

    a_r3_b_only: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && on_b && !on_a) |=> (pwm_out == !$past(act_pol)));

    a_r4_both_active: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && on_a && (a_act != '0)) |=> (pwm_out == $past(act_pol)));

    a_r5_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && on_a && (a_act == '0)) |=> (pwm_out == !$past(act_pol)));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(pwm_out));

    a_r8_buffer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_sel && !on_a) |=> ($stable(a_act) && $stable(b_act)));

    a_r9_force_inact: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && run_q && frc_inact) |=> (pwm_out == !$past(act_pol)));

    a_r9_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((frc_act || frc_inact) && !on_b && !match_flag) |=> !match_flag);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        on_b |=> match_flag);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_w1c && !on_b) |=> !match_flag);
endmodule

bind ocpwm_channel ocpwm_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .tbase(tbase),
    .run_en(run_en), .act_pol(act_pol), .upd_sel(upd_sel),
    .frc_act(frc_act), .frc_inact(frc_inact), .flag_w1c(flag_w1c),
    .a_act(a_act), .b_act(b_act), .run_q(run_q),
    .pwm_out(pwm_out), .match_flag(match_flag)
);

// File: tb/tb_ocpwm_channel.sv
`timescale 1ns/1ps
module tb_ocpwm_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic [23:0] tbase = '0;
    logic        run_en = 1'b0;
    logic        act_pol = 1'b0;
    logic        upd_sel = 1'b0;
    logic        wr_a = 1'b0;
    logic        wr_b = 1'b0;
    logic [23:0] wr_data = '0;
    logic        frc_act = 1'b0;
    logic        frc_inact = 1'b0;
    logic        flag_w1c = 1'b0;
    logic        pwm_out;
    logic        match_flag;
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    ocpwm_channel dut (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .tbase(tbase),
        .run_en(run_en), .act_pol(act_pol), .upd_sel(upd_sel),
        .wr_a(wr_a), .wr_b(wr_b), .wr_data(wr_data),
        .frc_act(frc_act), .frc_inact(frc_inact), .flag_w1c(flag_w1c),
        .pwm_out(pwm_out), .match_flag(match_flag)
    );

    // Table rows: {tick, tbase, expected pwm_out, expected match_flag}
    // with act_pol=1, cmp_a=0x200, cmp_b=0x900.
    localparam logic [26:0] VEC [8] = '{
        {1'b1, 24'h000100, 1'b0, 1'b0},  // R3 no match
        {1'b1, 24'h000200, 1'b1, 1'b0},  // R3 A match
        {1'b0, 24'h000900, 1'b1, 1'b0},  // R6 no tick
        {1'b1, 24'h000500, 1'b1, 1'b0},
        {1'b1, 24'h000900, 1'b0, 1'b1},  // R3 B match, R10 set
        {1'b1, 24'h000200, 1'b1, 1'b1},  // R11 flag set, still pulses
        {1'b0, 24'h000200, 1'b1, 1'b1},  // R6
        {1'b1, 24'h000900, 1'b0, 1'b1}   // R11
    };

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    // One clock edge, then release all strobes.
    task automatic cyc();
        @(posedge clk);
        #1;
        cnt_tick = 1'b0; wr_a = 1'b0; wr_b = 1'b0;
        frc_act = 1'b0; frc_inact = 1'b0; flag_w1c = 1'b0;
    endtask

    task automatic step(input logic tk, input logic [23:0] tb);
        @(negedge clk);
        cnt_tick = tk; tbase = tb;
        cyc();
    endtask

    task automatic write(input logic to_b, input logic [23:0] val);
        @(negedge clk);
        wr_a = !to_b; wr_b = to_b; wr_data = val;
        cyc();
    endtask

    task automatic strobe(input logic fa, input logic fi, input logic clr);
        @(negedge clk);
        frc_act = fa; frc_inact = fi; flag_w1c = clr;
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 out", pwm_out, 1'b0);
        check("R1 flag", match_flag, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        write(1'b0, 24'h000200);
        write(1'b1, 24'h000900);
        // Entry with act_pol=0 -> output 1.
        @(negedge clk); act_pol = 1'b0; run_en = 1'b1; cyc();
        check("R2 entry pol0", pwm_out, 1'b1);
        // Leave, tick at A match: held.
        @(negedge clk); run_en = 1'b0; cyc();
        step(1'b1, 24'h000200);
        check("R6 idle hold", pwm_out, 1'b1);
        check("R6 idle flag", match_flag, 1'b0);
        // Re-enter with act_pol=1 -> output 0.
        @(negedge clk); act_pol = 1'b1; run_en = 1'b1; cyc();
        check("R2 entry pol1", pwm_out, 1'b0);

        for (int i = 0; i < 8; i++) begin
            step(VEC[i][26], VEC[i][25:2]);
            check($sformatf("R3/R6/R11 row%0d out", i), pwm_out, VEC[i][1]);
            check($sformatf("R10 row%0d flag", i), match_flag, VEC[i][0]);
        end

        // R10: set and clear in the same cycle, then clear alone.
        @(negedge clk); flag_w1c = 1'b1; cnt_tick = 1'b1; tbase = 24'h000900; cyc();
        check("R10 set wins", match_flag, 1'b1);
        strobe(1'b0, 1'b0, 1'b1);
        check("R10 clear", match_flag, 1'b0);

        // R9 forces.
        strobe(1'b1, 1'b0, 1'b0);
        check("R9 force act", pwm_out, 1'b1);
        check("R9 flag untouched", match_flag, 1'b0);
        strobe(1'b0, 1'b1, 1'b0);
        check("R9 force inact", pwm_out, 1'b0);
        check("R9 flag untouched", match_flag, 1'b0);
        strobe(1'b1, 1'b0, 1'b0);
        strobe(1'b1, 1'b1, 1'b0);
        check("R9 both strobes", pwm_out, 1'b0);
        @(negedge clk); frc_act = 1'b1; cnt_tick = 1'b1; tbase = 24'h000900; cyc();
        check("R9 force over match", pwm_out, 1'b1);
        check("R10 match sets flag", match_flag, 1'b1);
        strobe(1'b0, 1'b0, 1'b1);

        // R7 immediate update.
        write(1'b1, 24'h000600);
        step(1'b1, 24'h000600);
        check("R7 immediate B", pwm_out, 1'b0);

        // R8 period update.
        @(negedge clk); upd_sel = 1'b1; cyc();
        strobe(1'b1, 1'b0, 1'b1);
        write(1'b1, 24'h000400);
        write(1'b0, 24'h000300);
        step(1'b1, 24'h000400);
        check("R8 B still old", pwm_out, 1'b1);
        step(1'b1, 24'h000300);
        check("R8 A still old", pwm_out, 1'b1);
        step(1'b1, 24'h000200);
        check("R8 old A match", pwm_out, 1'b1);
        step(1'b1, 24'h000600);
        check("R8 old B gone", pwm_out, 1'b1);
        step(1'b1, 24'h000400);
        check("R8 new B active", pwm_out, 1'b0);
        step(1'b1, 24'h000300);
        check("R8 new A active", pwm_out, 1'b1);
        @(negedge clk); upd_sel = 1'b0; cyc();

        // R4 100% duty.
        write(1'b0, 24'h000700);
        write(1'b1, 24'h000700);
        strobe(1'b0, 1'b1, 1'b1);
        step(1'b1, 24'h000700);
        check("R4 equal match", pwm_out, 1'b1);
        check("R4 flag", match_flag, 1'b1);
        step(1'b1, 24'h000700);
        check("R4 next period", pwm_out, 1'b1);

        // R5 0% duty.
        write(1'b0, 24'h000000);
        strobe(1'b1, 1'b0, 1'b0);
        step(1'b1, 24'h000000);
        check("R5 zero A", pwm_out, 1'b0);
        write(1'b1, 24'h000000);
        strobe(1'b1, 1'b0, 1'b0);
        step(1'b1, 24'h000000);
        check("R5 zero pair", pwm_out, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule